// File: doc/BRIEF.md
# MESI Snooping Line State Controller

This block keeps the four-state coherence tag of every line in a private cache that sits on a shared snooping bus. In each cycle it can take one local access and one snooped transaction. The local access is a read or a write that the processor makes against one line index. The snooped transaction is either another cache reading a line or another cache announcing that it will write one. For each access the block decides the line's next state, whether a bus request is needed and which kind, and whether a snooped hit on dirty data must be written back.

The data array, the bus arbiter and the memory side are outside this block. A bus request raised here is treated as completing in the same cycle. For a read fill, the shared-line response is presented on `fill_shared` in that cycle. When the snoop and the local access name the same line, the snoop is applied first, and the local access is then decided against the state the snoop leaves behind.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset, every line reads back state Invalid (code 00) on `cpu_prev_state`.
- R2: A local read to an Invalid line raises bus request 01 (read). The line becomes Shared (01) when `fill_shared` is 1 and Exclusive (10) when it is 0.
- R3: A local write to an Exclusive line raises no bus request (00), and the line becomes Modified (11).
- R4: A local write to an Invalid line raises bus request 10 (read with intent to modify), and the line becomes Modified.
- R5: A local write to a Shared line raises bus request 11 (upgrade, invalidating other copies), and the line becomes Modified.
- R6: A snooped read that hits a Modified line asserts `snp_writeback` and leaves the line Shared.
- R7: A snooped read that hits an Exclusive line leaves it Shared without a write-back. Snooped reads of Shared or Invalid lines change nothing.
- R8: A snooped intent-to-write makes the line Invalid, and asserts `snp_writeback` only when the line was Modified.
- R9: Local reads and writes that hit Modified keep Modified, and reads that hit Shared or Exclusive keep their state. None of these raise a bus request.
- R10: When a snoop and a local access name the same line in the same cycle, `cpu_prev_state` shows the state after the snoop, and the local decision is based on that state.
- R11: State codes are I=00, S=01, E=10, M=11. A snoop and a local access to different lines in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Local access present |
| cpu_write | input | 1 | Local access is a write (0 = read) |
| cpu_index | input | IW | Line index of the local access |
| fill_shared | input | 1 | Another cache holds the line being read-filled |
| snp_valid | input | 1 | Snooped transaction present |
| snp_intent_wr | input | 1 | Snoop is an intent to write (0 = read) |
| snp_index | input | IW | Line index of the snoop |
| bus_req | output | 2 | 00 none, 01 read, 10 read for ownership, 11 upgrade |
| snp_writeback | output | 1 | Snooped line is dirty and must be written back |
| cpu_prev_state | output | 2 | State the local access is judged against |
| cpu_next_state | output | 2 | State the local line takes at the next edge |

## Verification
The bench targets the collision case, where a snoop and a local write hit the same line. A design that decided the local write against the stale state would report a silent upgrade or an upgrade where a full read-for-ownership is due, and it would leave the line in the wrong state. It checks that a write to Exclusive stays off the bus, because a design that treated Exclusive like Shared would issue a needless upgrade. It checks that write-back fires only from Modified, since a loose design would also write back clean Exclusive data. Long mixed traffic across lines, with both events in the same cycle, exposes any case where one of two simultaneous updates is lost.

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int LINES = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cpu_valid,
  input  logic                                  cpu_write,
  input  logic [((LINES > 1) ? $clog2(LINES) : 1)-1:0] cpu_index,
  input  logic                                  fill_shared,
  input  logic                                  snp_valid,
  input  logic                                  snp_intent_wr,
  input  logic [((LINES > 1) ? $clog2(LINES) : 1)-1:0] snp_index,
  output logic [1:0]                            bus_req,
  output logic                                  snp_writeback,
  output logic [1:0]                            cpu_prev_state,
  output logic [1:0]                            cpu_next_state
);
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [1:0] ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11;
  localparam logic [1:0] BR_NONE = 2'b00, BR_RD = 2'b01, BR_RFO = 2'b10, BR_UPG = 2'b11;

  logic [1:0] st [LINES];
  logic [1:0] snp_cur, snp_nxt;
  logic       collide;

  assign snp_cur       = st[snp_index];
  assign snp_writeback = snp_valid && (snp_cur == ST_M);
  assign collide       = snp_valid && cpu_valid && (snp_index == cpu_index);

  always_comb begin
    if (!snp_valid)         snp_nxt = snp_cur;
    else if (snp_intent_wr) snp_nxt = ST_I;
    else                    snp_nxt = (snp_cur == ST_I) ? ST_I : ST_S;
  end

  assign cpu_prev_state = collide ? snp_nxt : st[cpu_index];

  always_comb begin
    bus_req        = BR_NONE;
    cpu_next_state = cpu_prev_state;
    if (cpu_valid) begin
      if (cpu_write) begin
        cpu_next_state = ST_M;
        case (cpu_prev_state)
          ST_I:    bus_req = BR_RFO;
          ST_S:    bus_req = BR_UPG;
          default: bus_req = BR_NONE;
        endcase
      end else if (cpu_prev_state == ST_I) begin
        bus_req        = BR_RD;
        cpu_next_state = fill_shared ? ST_S : ST_E;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st[i] <= ST_I;
    end else begin
      if (snp_valid) st[snp_index] <= snp_nxt;
      if (cpu_valid) st[cpu_index] <= cpu_next_state;
    end
  end

  assert_silent_e_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_write && cpu_prev_state == ST_E) |-> (bus_req == BR_NONE));

  assert_modified_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_prev_state == ST_M) |=> (st[$past(cpu_index)] == ST_M));

  assert_snoop_invalidates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_intent_wr && !(cpu_valid && cpu_index == snp_index))
      |=> (st[$past(snp_index)] == ST_I));

  assert_wb_needs_snoop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_writeback |-> snp_valid);

  assert_bus_needs_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req != BR_NONE) |-> cpu_valid);

  assert_write_ends_m_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_write) |=> (st[$past(cpu_index)] == ST_M));
endmodule

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, cpu_write = 0, fill_shared = 0, snp_valid = 0, snp_intent_wr = 0;
  logic [IW-1:0] cpu_index = '0, snp_index = '0;
  logic [1:0] bus_req, cpu_prev_state, cpu_next_state;
  logic snp_writeback;

  int n_tests = 0, n_fail = 0;
  int ms [LINES];
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mesi_line_ctrl #(.LINES(LINES)) i_mesi_line_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_index(cpu_index), .fill_shared(fill_shared), .snp_valid(snp_valid),
    .snp_intent_wr(snp_intent_wr), .snp_index(snp_index), .bus_req(bus_req),
    .snp_writeback(snp_writeback), .cpu_prev_state(cpu_prev_state),
    .cpu_next_state(cpu_next_state));

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit cv, bit cw, int ci, bit fs, bit sv, bit sw, int si);
    int sp, sn, cp, cn, br;
    bit wb;
    @(negedge clk);
    cpu_valid = cv; cpu_write = cw; cpu_index = IW'(ci); fill_shared = fs;
    snp_valid = sv; snp_intent_wr = sw; snp_index = IW'(si);
    #1;
    sp = ms[si];
    if (!sv) sn = sp; else if (sw) sn = 0; else sn = (sp == 0) ? 0 : 1;
    wb = sv && sp == 3;
    cp = (sv && cv && si == ci) ? sn : ms[ci];
    cn = cp; br = 0;
    if (cv) begin
      if (cw) begin cn = 3; br = (cp == 0) ? 2 : (cp == 1) ? 3 : 0; end
      else if (cp == 0) begin br = 1; cn = fs ? 1 : 2; end
    end
    chk(tag, "bus_req", int'(bus_req), br);
    chk(tag, "snp_writeback", int'(snp_writeback), int'(wb));
    chk(tag, "cpu_prev_state", int'(cpu_prev_state), cp);
    chk(tag, "cpu_next_state", int'(cpu_next_state), cn);
    @(posedge clk);
    if (sv) ms[si] = sn;
    if (cv) ms[ci] = cn;
  endtask

  initial begin
    while (cyc < 50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    for (int i = 0; i < LINES; i++) ms[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < LINES; i++) step("R1", 0, 0, i, 0, 0, 0, 0);
    step("R2", 1, 0, 1, 0, 0, 0, 0);
    step("R2", 1, 0, 2, 1, 0, 0, 0);
    step("R3", 1, 1, 1, 0, 0, 0, 0);
    step("R9", 1, 0, 1, 0, 0, 0, 0);
    step("R9", 1, 1, 1, 0, 0, 0, 0);
    step("R9", 1, 0, 2, 0, 0, 0, 0);
    step("R4", 1, 1, 3, 0, 0, 0, 0);
    step("R5", 1, 1, 2, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 0, 1, 0, 1);
    step("R6", 0, 0, 1, 0, 0, 0, 0);
    step("R7", 1, 0, 4, 0, 0, 0, 0);
    step("R7", 0, 0, 4, 0, 1, 0, 4);
    step("R7", 0, 0, 4, 0, 1, 0, 4);
    step("R7", 0, 0, 5, 0, 1, 0, 5);
    step("R7", 1, 0, 9, 0, 1, 0, 5);
    step("R8", 0, 0, 3, 0, 1, 1, 3);
    step("R8", 0, 0, 3, 0, 1, 1, 4);
    step("R8", 0, 0, 4, 0, 0, 0, 0);
    step("R10", 1, 0, 6, 0, 0, 0, 0);
    step("R10", 1, 1, 6, 0, 1, 1, 6);
    step("R10", 1, 1, 6, 0, 1, 0, 6);
    step("R10", 1, 0, 6, 1, 1, 1, 6);
    step("R11", 1, 1, 7, 0, 1, 1, 2);
    seed = 7;
    for (int k = 0; k < 600; k++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      step("R11", seed[16], seed[17], (seed >> 4) & 7, seed[18], seed[19],
           seed[20], (seed >> 8) & 7);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule